// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the interrupt status word of a USB 2.0 host controller. Other parts of the controller report events to it: a transfer finished, a transfer failed, a root port changed state, the periodic frame list wrapped, and a host memory access failed. Each event sets a sticky status bit. Software clears a bit by writing a one to it. A level interrupt goes out whenever a set bit is also enabled in the separate interrupt-enable register, whose value arrives here as an input.

The block finds two kinds of event on its own by edge detection. It spots a frame list wrap by watching one bit of the running frame index, and a port event by watching each root port's change and resume-request levels. A failed host memory access also sends a one-cycle request to the command logic to drop the run flag. When the controller returns to the active power state, a rebuild strobe reloads the port-change bit from the current port levels.

Top module: `usb_host_irq_status`

## Requirements
- R1: After reset, bits 4..0 of the read word are 0, the interrupt output is low, the run-clear request is low, and the read word equals 0x00001000 while the halted input is 1.
- R2: A write sets the register only through write-one-to-clear: a 1 in bit positions 0..4 clears that status bit, a 0 leaves it unchanged, and a status bit with no write stays set.
- R3: Bit 0 (completion) is set one cycle after a transfer-done strobe that has its interrupt-on-complete flag or its short-packet flag set.
- R4: Bit 1 (error) is set one cycle after a transfer-done strobe with the error flag set. If interrupt-on-complete is also set, bits 0 and 1 are both set in that same cycle.
- R5: Bit 2 (port change) is set when a port's change level rises from 0 to 1, but only for a port whose owner input is 0. A change level that stays high does not set the bit again, and ports whose owner input is 1 are ignored.
- R6: Bit 2 is also set when a host-owned port's force-resume level rises from 0 to 1.
- R7: Bit 3 (frame wrap) is set one cycle after frame index bit 13 differs from its value in the previous cycle, in either direction. Changes to the other index bits do not set it, and no wrap is reported in the first cycle after reset.
- R8: A memory-access-done strobe with the success flag low sets bit 4 and raises the run-clear request for exactly one cycle, in the same cycle that bit 4 becomes set.
- R9: The interrupt output is 1 exactly when some bit i in 0..4 is set in the status and bit i of the interrupt-enable input is also 1.
- R10: When a set event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Bit 12 of the read word always equals the halted input. All other bits from 5 to 31 read 0, and writes to them have no effect.
- R12: A rebuild strobe loads bit 2 with the OR of every port's change and force-resume levels, whatever the port's owner. A port-change set event in the same cycle still sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the status word |
| regWrData | input | 32 | Write data (a one clears the status bit at that position) |
| regRdData | output | 32 | Current status word |
| intrEnable | input | 5 | Per-bit interrupt enables for bits 0..4 |
| haltedIn | input | 1 | Controller halted flag, shown at bit 12 |
| txnDone | input | 1 | Transfer completion strobe |
| txnIoc | input | 1 | Completed descriptor requested an interrupt |
| txnShort | input | 1 | Completed transfer was a short packet |
| txnErr | input | 1 | Completed transfer ended in error |
| frameIndex | input | 14 | Running frame index |
| portChange | input | 4 | Per-port OR of the change levels |
| portOwner | input | 4 | Per-port owner (0 means the host owns the port) |
| portForceResume | input | 4 | Per-port force-resume level |
| resumeRebuild | input | 1 | Reload strobe on return to the active power state |
| memAccDone | input | 1 | Host memory access completion strobe |
| memAccOk | input | 1 | Completed access ended successfully |
| clrRunStop | output | 1 | One-cycle request to clear the run flag |
| irqOut | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: four root ports, a 14-bit frame index that watches bit 13, and a 32-bit word with the halted flag at bit 12. With four ports, the random stimulus can mix host-owned and foreign ports in one cycle, and it often produces change and resume rises on several ports at once. Watching bit 13 of a 14-bit index lets the bench wrap the frame index directly, and also change only the low bits, which must not count as a wrap. The 32-bit word leaves room to write the unused upper bits and check that they stay zero.

// File: rtl/usb_sts_pkg.sv
package usb_sts_pkg;

  localparam int STS_BITS   = 5;
  localparam int BIT_CMPL   = 0;
  localparam int BIT_ERR    = 1;
  localparam int BIT_PORT   = 2;
  localparam int BIT_ROLL   = 3;
  localparam int BIT_SYSERR = 4;

  // Strobes from the event decoder to the status datapath
  typedef struct packed {
    logic [STS_BITS-1:0] setMask;
    logic [STS_BITS-1:0] clrMask;
    logic                rebuildLoad;
    logic                rebuildVal;
  } stsStrobes_t;

endpackage

// File: rtl/usb_sts_ctrl.sv
module usb_sts_ctrl
  import usb_sts_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FRAME_W   = 14,
  parameter int ROLL_BIT  = 13,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 txnDone,
  input  logic                 txnIoc,
  input  logic                 txnShort,
  input  logic                 txnErr,
  input  logic [FRAME_W-1:0]   frameIndex,
  input  logic [NUM_PORTS-1:0] portChange,
  input  logic [NUM_PORTS-1:0] portOwner,
  input  logic [NUM_PORTS-1:0] portForceResume,
  input  logic                 resumeRebuild,
  input  logic                 memAccDone,
  input  logic                 memAccOk,
  output stsStrobes_t          strobes
);

  logic [NUM_PORTS-1:0] prevChange;
  logic [NUM_PORTS-1:0] prevResume;
  logic [NUM_PORTS-1:0] hostRise;
  logic [NUM_PORTS-1:0] anyLevel;
  logic                 prevRoll;
  logic                 primed;
  logic                 rollToggle;

  // Bits outside the status field and the watched index bit are not decoded
  logic unusedInputs;
  assign unusedInputs = ^{regWrData[DATA_W-1:STS_BITS], frameIndex};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevChange <= '0;
      prevResume <= '0;
      prevRoll   <= 1'b0;
      primed     <= 1'b0;
    end else begin
      prevChange <= portChange;
      prevResume <= portForceResume;
      prevRoll   <= frameIndex[ROLL_BIT];
      primed     <= 1'b1;
    end
  end

  // Per-port rise detection, qualified by host ownership
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic chgRise;
    logic resRise;
    assign chgRise     = portChange[p] & ~prevChange[p];
    assign resRise     = portForceResume[p] & ~prevResume[p];
    assign hostRise[p] = ~portOwner[p] & (chgRise | resRise);
    assign anyLevel[p] = portChange[p] | portForceResume[p];
  end

  assign rollToggle = primed & (frameIndex[ROLL_BIT] ^ prevRoll);

  always_comb begin
    strobes                      = '0;
    strobes.setMask[BIT_CMPL]    = txnDone & (txnIoc | txnShort);
    strobes.setMask[BIT_ERR]     = txnDone & txnErr;
    strobes.setMask[BIT_PORT]    = |hostRise;
    strobes.setMask[BIT_ROLL]    = rollToggle;
    strobes.setMask[BIT_SYSERR]  = memAccDone & ~memAccOk;
    strobes.clrMask              = regWrEn ? regWrData[STS_BITS-1:0] : '0;
    strobes.rebuildLoad          = resumeRebuild;
    strobes.rebuildVal           = |anyLevel;
  end

endmodule

// File: rtl/usb_sts_datapath.sv
module usb_sts_datapath
  import usb_sts_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HALT_BIT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stsStrobes_t         strobes,
  input  logic [STS_BITS-1:0] intrEnable,
  input  logic                haltedIn,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut,
  output logic                clrRunStop
);

  logic [STS_BITS-1:0] stsQ;
  logic [STS_BITS-1:0] stsNext;
  logic                runClrQ;

  // Next state per status bit: set beats clear; the port bit may be reloaded
  for (genvar b = 0; b < STS_BITS; b++) begin : g_bit
    if (b == BIT_PORT) begin : g_reload
      assign stsNext[b] = strobes.rebuildLoad
                        ? (strobes.rebuildVal | strobes.setMask[b])
                        : (strobes.setMask[b] | (stsQ[b] & ~strobes.clrMask[b]));
    end else begin : g_plain
      assign stsNext[b] = strobes.setMask[b] | (stsQ[b] & ~strobes.clrMask[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stsQ    <= '0;
      runClrQ <= 1'b0;
    end else begin
      stsQ    <= stsNext;
      runClrQ <= strobes.setMask[BIT_SYSERR];
    end
  end

  always_comb begin
    regRdData                 = '0;
    regRdData[STS_BITS-1:0]   = stsQ;
    regRdData[HALT_BIT]       = haltedIn;
  end

  assign irqOut     = |(stsQ & intrEnable);
  assign clrRunStop = runClrQ;

endmodule

// File: rtl/usb_host_irq_status.sv
module usb_host_irq_status
  import usb_sts_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FRAME_W   = 14,
  parameter int ROLL_BIT  = 13,
  parameter int DATA_W    = 32,
  parameter int HALT_BIT  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [STS_BITS-1:0]  intrEnable,
  input  logic                 haltedIn,
  input  logic                 txnDone,
  input  logic                 txnIoc,
  input  logic                 txnShort,
  input  logic                 txnErr,
  input  logic [FRAME_W-1:0]   frameIndex,
  input  logic [NUM_PORTS-1:0] portChange,
  input  logic [NUM_PORTS-1:0] portOwner,
  input  logic [NUM_PORTS-1:0] portForceResume,
  input  logic                 resumeRebuild,
  input  logic                 memAccDone,
  input  logic                 memAccOk,
  output logic                 clrRunStop,
  output logic                 irqOut
);

  stsStrobes_t strobes;

  usb_sts_ctrl #(
    .NUM_PORTS(NUM_PORTS), .FRAME_W(FRAME_W), .ROLL_BIT(ROLL_BIT), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .txnDone(txnDone), .txnIoc(txnIoc), .txnShort(txnShort), .txnErr(txnErr),
    .frameIndex(frameIndex),
    .portChange(portChange), .portOwner(portOwner), .portForceResume(portForceResume),
    .resumeRebuild(resumeRebuild),
    .memAccDone(memAccDone), .memAccOk(memAccOk),
    .strobes(strobes)
  );

  usb_sts_datapath #(
    .DATA_W(DATA_W), .HALT_BIT(HALT_BIT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n),
    .strobes(strobes),
    .intrEnable(intrEnable), .haltedIn(haltedIn),
    .regRdData(regRdData), .irqOut(irqOut), .clrRunStop(clrRunStop)
  );

endmodule

// File: rtl/usb_host_irq_status_chk.sv
module usb_host_irq_status_chk #(
  parameter int DATA_W   = 32,
  parameter int HALT_BIT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [4:0]        intrEnable,
  input logic              haltedIn,
  input logic              txnDone,
  input logic              txnIoc,
  input logic              txnShort,
  input logic              txnErr,
  input logic              memAccDone,
  input logic              memAccOk,
  input logic              clrRunStop,
  input logic              irqOut
);

  assert_syserr_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (memAccDone && !memAccOk) |=> (clrRunStop && regRdData[4]));

  assert_runclr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clrRunStop |-> $past(memAccDone && !memAccOk));

  assert_cmpl_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txnDone && (txnIoc || txnShort)) |=> regRdData[0]);

  assert_err_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txnDone && txnErr && txnIoc) |=> (regRdData[1:0] == 2'b11));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[0] && !(txnDone && (txnIoc || txnShort))) |=> !regRdData[0]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[0] && !regWrEn) |=> regRdData[0]);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == (|(regRdData[4:0] & intrEnable)));

  assert_halt_mirror_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[HALT_BIT] == haltedIn) && (regRdData[DATA_W-1:HALT_BIT+1] == '0)
    && (regRdData[HALT_BIT-1:5] == '0));

endmodule

bind usb_host_irq_status usb_host_irq_status_chk #(.DATA_W(DATA_W), .HALT_BIT(HALT_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .intrEnable(intrEnable), .haltedIn(haltedIn),
  .txnDone(txnDone), .txnIoc(txnIoc), .txnShort(txnShort), .txnErr(txnErr),
  .memAccDone(memAccDone), .memAccOk(memAccOk), .clrRunStop(clrRunStop), .irqOut(irqOut)
);

// File: tb/usb_host_irq_status_tb.sv
module usb_host_irq_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [4:0]  intrEnable;
  logic        haltedIn;
  logic        txnDone, txnIoc, txnShort, txnErr;
  logic [13:0] frameIndex;
  logic [3:0]  portChange, portOwner, portForceResume;
  logic        resumeRebuild, memAccDone, memAccOk;
  logic        clrRunStop, irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state kept by the bench
  logic [4:0] mSts;
  logic [3:0] mPrevChg, mPrevRes;
  logic       mPrevRoll, mPrimed, mClr;

  always #5 clk = ~clk;

  usb_host_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .intrEnable(intrEnable), .haltedIn(haltedIn),
    .txnDone(txnDone), .txnIoc(txnIoc), .txnShort(txnShort), .txnErr(txnErr),
    .frameIndex(frameIndex), .portChange(portChange), .portOwner(portOwner),
    .portForceResume(portForceResume), .resumeRebuild(resumeRebuild),
    .memAccDone(memAccDone), .memAccOk(memAccOk),
    .clrRunStop(clrRunStop), .irqOut(irqOut)
  );

  function automatic logic [4:0] calcSet();
    logic [4:0] s;
    logic [3:0] rise;
    rise = ~portOwner & ((portChange & ~mPrevChg) | (portForceResume & ~mPrevRes));
    s[0] = txnDone & (txnIoc | txnShort);
    s[1] = txnDone & txnErr;
    s[2] = |rise;
    s[3] = mPrimed & (frameIndex[13] ^ mPrevRoll);
    s[4] = memAccDone & ~memAccOk;
    return s;
  endfunction

  function automatic logic [4:0] calcNext(input logic [4:0] s);
    logic [4:0] c, n;
    c = regWrEn ? regWrData[4:0] : 5'd0;
    n = s | (mSts & ~c);
    if (resumeRebuild) n[2] = (|(portChange | portForceResume)) | s[2];
    return n;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check32(tag, regRdData, {19'd0, haltedIn, 7'd0, mSts});
    check32("R9 irq", {31'd0, irqOut}, {31'd0, |(mSts & intrEnable)});
    check32("R8 runclr", {31'd0, clrRunStop}, {31'd0, mClr});
  endtask

  task automatic step(input string tag);
    logic [4:0] s, n;
    s = calcSet();
    n = calcNext(s);
    @(posedge clk);
    mSts = n;
    mClr = s[4];
    mPrevChg = portChange;
    mPrevRes = portForceResume;
    mPrevRoll = frameIndex[13];
    mPrimed = 1'b1;
    #2;
    checkOutputs(tag);
  endtask

  task automatic quiet();
    regWrEn = 0; regWrData = '0; txnDone = 0; txnIoc = 0; txnShort = 0; txnErr = 0;
    resumeRebuild = 0; memAccDone = 0; memAccOk = 1;
  endtask

  task automatic wr(input logic [31:0] d);
    regWrEn = 1; regWrData = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; quiet(); intrEnable = '0; haltedIn = 1; frameIndex = '0;
    portChange = '0; portOwner = '0; portForceResume = '0;
    mSts = '0; mPrevChg = '0; mPrevRes = '0; mPrevRoll = 0; mPrimed = 0; mClr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    check32("R1 reset word", regRdData, 32'h0000_1000);
    check32("R1 irq", {31'd0, irqOut}, 32'd0);
    check32("R1 runclr", {31'd0, clrRunStop}, 32'd0);

    // R7 no wrap reported on first cycle even though bit 13 starts high
    frameIndex = 14'h2000; step("R7 first cycle");
    haltedIn = 0; step("R11 halted low");
    // R3 completion
    txnDone = 1; txnIoc = 1; step("R3 ioc");
    quiet(); wr(32'h0); step("R2 write zero");
    quiet(); wr(32'h1); step("R2 clear bit0");
    quiet(); txnDone = 1; txnShort = 1; step("R3 short");
    quiet(); txnDone = 1; txnIoc = 0; step("R3 no flags");
    // R4
    quiet(); wr(32'h1F); step("R2 clear all");
    quiet(); txnDone = 1; txnErr = 1; txnIoc = 1; step("R4 both");
    quiet(); wr(32'h3); step("R2 clear both");
    quiet(); txnDone = 1; txnErr = 1; step("R4 error only");
    // R5 ports
    quiet(); wr(32'h1F); step("R2 clear");
    quiet(); portChange = 4'b0010; step("R5 owned rise");
    wr(32'h4); step("R5 held level");
    quiet(); step("R5 held no reset");
    portOwner = 4'b1000; portChange = 4'b1010; step("R5 foreign port");
    portChange = 4'b0000; portOwner = 4'b0000; step("R5 falling");
    // R6
    portForceResume = 4'b0100; step("R6 resume rise");
    wr(32'h4); step("R6 clear");
    quiet(); portForceResume = 4'b0000; step("R6 fall");
    // R7
    frameIndex = 14'h0000; step("R7 toggle down");
    wr(32'h8); step("R7 clear");
    quiet(); frameIndex = 14'h1FFF; step("R7 low bits");
    frameIndex = 14'h2000; step("R7 toggle up");
    // R8
    quiet(); memAccDone = 1; memAccOk = 0; step("R8 syserr");
    quiet(); step("R8 pulse ends");
    memAccDone = 1; memAccOk = 1; step("R8 success access");
    // R9
    quiet(); intrEnable = 5'b10000; step("R9 enabled");
    intrEnable = 5'b00100; step("R9 disabled bit");
    // R10
    wr(32'h1F); txnDone = 1; txnIoc = 1; memAccDone = 1; memAccOk = 0; step("R10 set wins");
    quiet(); wr(32'hFFFF_FFE0); step("R11 upper write ignored");
    haltedIn = 1; step("R11 halted high");
    // R12
    quiet(); wr(32'h1F); step("R2 clear all");
    quiet(); portOwner = 4'b0001; portChange = 4'b0001; step("R12 foreign high");
    resumeRebuild = 1; step("R12 rebuild sets");
    quiet(); portChange = 4'b0000; resumeRebuild = 1; step("R12 rebuild clears");
    quiet(); portOwner = 4'b0000;

    // Constrained random mix (collisions of set and clear included: R10)
    for (int i = 0; i < 4000; i++) begin
      regWrEn = ($urandom % 4) == 0;
      regWrData = $urandom;
      txnDone = ($urandom % 3) == 0;
      txnIoc = $urandom % 2; txnShort = ($urandom % 5) == 0; txnErr = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) frameIndex = 14'($urandom);
      if (($urandom % 4) == 0) portChange = 4'($urandom);
      if (($urandom % 5) == 0) portForceResume = 4'($urandom);
      if (($urandom % 8) == 0) portOwner = 4'($urandom);
      resumeRebuild = ($urandom % 20) == 0;
      memAccDone = ($urandom % 6) == 0; memAccOk = ($urandom % 2);
      if (($urandom % 10) == 0) intrEnable = 5'($urandom);
      if (($urandom % 30) == 0) haltedIn = ~haltedIn;
      step("R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule